// File: doc/BRIEF.md
# Byte-Buffer Programmed-I/O Data Port

This block lets a host processor fill and drain two byte-organised transfer buffers, one for isochronous traffic and one for asynchronous traffic, through a single 16-bit data port. The processor writes a command code on the command strobe (`cmd_sel` high). The code picks a buffer and a direction. After that, any number of data-port strobes stream through the chosen buffer. Each strobe moves two bytes and advances an internal byte pointer by two.

The stream closes by itself when the pointer reaches a byte count that software programmed beforehand. At that point an end-of-transfer event does three things: it sets the sticky all-transfers-done flag (bit 2 of the interrupt register), it raises `irq`, and it marks the buffer as done in the status register.

The same command path also selects the internal registers. These are the transfer count, the interrupt register and the buffer status. A data strobe after a register command reads or writes the selected register. `DEPTH` must be a power of two.

Top module: `pio_buf_port`

## Requirements
- R1: After reset, `irq` is 0, the transfer count is 0, both status bits are 0, no stream is open and `rdata` is 0.
- R2: Command 40h opens a read stream on the isochronous buffer and C0h opens a write stream on it. Command 41h opens a read stream on the asynchronous buffer and C1h opens a write stream on it. The two buffers hold independent contents.
- R3: In a stream, `wdata[7:0]` / `rdata[7:0]` carry the byte at the even pointer address and `wdata[15:8]` / `rdata[15:8]` carry the byte at the next odd address.
- R4: Each data access in an open stream advances the pointer by 2. Every accepted buffer command restarts the pointer at 0.
- R5: When an access brings the pointer to or past the transfer count, the stream closes. On the following cycle `irq` is 1 and interrupt register bit 2 reads 1.
- R6: Once the stream has closed, data writes leave the buffer unchanged and data reads return 0.
- R7: With an odd transfer count, the last access of a write stream stores only its low byte, and the last access of a read stream returns 0 in the high byte.
- R8: The interrupt flag stays set until software issues command A4h and then writes a data word with bit 2 set. A data word with bit 2 clear leaves it set. Command 24h reads the interrupt register, with the flag at bit 2.
- R9: After command C2h, a data write loads the transfer count, saturating at `DEPTH`. Command 42h reads the count back. A count of 0 opens no stream.
- R10: After command 2Ch, data reads return the buffer status. Bit 0 is isochronous done and bit 1 is asynchronous done. A buffer's bit is set at its end of transfer and cleared when a new command for that buffer is accepted.
- R11: A data access whose direction differs from the open stream does not move the pointer and does not alter the buffer. A read in a write stream returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select qualifying `wr` and `rd` |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe, one access per cycle; ignored while `wr` is high |
| cmd_sel | input | 1 | 1 = command write, 0 = data access |
| wdata | input | 16 | Write data; the command code is in bits 7:0 |
| rdata | output | 16 | Read data, valid while the read strobe is high |
| irq | output | 1 | Level copy of the sticky all-transfers-done flag |

## Verification
The last access of a stream does two jobs in the same clock edge. It moves data, and for odd counts it moves only the low lane. It also raises the end-of-transfer flag, `irq` and the buffer status bit. The sweep covers every count from 0 to two past `DEPTH` on both buffers, so even and odd final accesses, the full-buffer case and saturation all occur. Each one is judged in three ways: `irq` must read low just before the final access and high right after it, the status read must show the buffer as done, and a full readback of the buffer must show the byte just beyond the count still holding its earlier background value.

// File: rtl/pio_buf_port.sv
module pio_buf_port #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        wr,
  input  logic        rd,
  input  logic        cmd_sel,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [7:0] C_CNT_WR  = 8'hC2;
  localparam logic [7:0] C_CNT_RD  = 8'h42;
  localparam logic [7:0] C_INT_RD  = 8'h24;
  localparam logic [7:0] C_INT_CLR = 8'hA4;
  localparam logic [7:0] C_STAT_RD = 8'h2C;

  logic [7:0]    cmd_q;
  logic [CW-1:0] ptr, count;
  logic          active, int_all;
  logic [1:0]    stat;
  logic [7:0]    mem [2][DEPTH];

  wire wr_cmd = cs & wr & cmd_sel;
  wire wr_dat = cs & wr & ~cmd_sel;
  wire rd_dat = cs & rd & ~wr & ~cmd_sel;

  wire is_buf  = (cmd_q[6:1] == 6'b100000);
  wire new_buf = (wdata[6:1] == 6'b100000);
  wire bsel    = cmd_q[0];
  wire dir_w   = cmd_q[7];
  wire acc     = active & (dir_w ? wr_dat : rd_dat);

  wire [CW-1:0] ptr_nx = ptr + CW'(2);
  wire          hi_ok  = (ptr + CW'(1)) < count;
  wire          last   = ptr_nx >= count;
  wire [AW-1:0] lo_a   = ptr[AW-1:0];
  wire [AW-1:0] hi_a   = lo_a + AW'(1);
  wire [CW-1:0] cnt_in = (wdata > 16'(DEPTH)) ? DEPTH_C : wdata[CW-1:0];

  assign irq = int_all;

  always_comb begin
    rdata = '0;
    if (is_buf && !dir_w) begin
      if (active) rdata = {hi_ok ? mem[bsel][hi_a] : 8'h00, mem[bsel][lo_a]};
    end else begin
      case (cmd_q)
        C_CNT_RD:  rdata = 16'(count);
        C_INT_RD:  rdata = {13'b0, int_all, 2'b0};
        C_STAT_RD: rdata = {14'b0, stat};
        default:   rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ptr     <= '0;
      count   <= '0;
      active  <= 1'b0;
      int_all <= 1'b0;
      stat    <= '0;
    end else if (wr_cmd) begin
      cmd_q  <= wdata[7:0];
      ptr    <= '0;
      active <= new_buf && (count != '0);
      if (new_buf) stat[wdata[0]] <= 1'b0;
    end else if (acc) begin
      ptr <= ptr_nx;
      if (last) begin
        active     <= 1'b0;
        int_all    <= 1'b1;
        stat[bsel] <= 1'b1;
      end
    end else if (wr_dat) begin
      if (cmd_q == C_CNT_WR) count <= cnt_in;
      if (cmd_q == C_INT_CLR && wdata[2]) int_all <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && dir_w) begin
      mem[bsel][lo_a] <= wdata[7:0];
      if (hi_ok) mem[bsel][hi_a] <= wdata[15:8];
    end
  end
endmodule

// File: rtl/pio_buf_port_chk.sv
module pio_buf_port_chk #(
  parameter int DEPTH = 64,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          wr,
  input logic          cmd_sel,
  input logic [15:0]   wdata,
  input logic          irq,
  input logic          acc,
  input logic          wr_cmd,
  input logic          active,
  input logic [CW-1:0] ptr,
  input logic [CW-1:0] count
);
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !wr_cmd |=> ptr == $past(ptr) + CW'(2));

  p_ptr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> ptr == '0);

  p_eot_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (ptr + CW'(2) >= count) |=> irq && !active);

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(acc));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !wr_cmd |=> $stable(ptr));

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(cs && wr && !cmd_sel && wdata[2]));

  p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_window_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ptr < count);
endmodule

bind pio_buf_port pio_buf_port_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .cmd_sel(cmd_sel),
  .wdata(wdata), .irq(irq), .acc(acc), .wr_cmd(wr_cmd),
  .active(active), .ptr(ptr), .count(count)
);

// File: tb/pio_buf_port_test.sv
module pio_buf_port_test;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0, cs = 0, wr = 0, rd = 0, cmd_sel = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;
  int nchk = 0, nfail = 0;
  logic [1:0] exp_stat = '0;

  pio_buf_port #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd),
    .cmd_sel(cmd_sel), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] bg(int b, int i);
    return 8'(i * 7 + b * 50 + 3);
  endfunction
  function automatic logic [7:0] fg(int b, int c, int i);
    return 8'(i * 13 + c + b * 91 + 1);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic [15:0] d);
    @(negedge clk); cs = 1; wr = 1; cmd_sel = c; wdata = d;
    @(negedge clk); cs = 0; wr = 0; cmd_sel = 0; wdata = '0;
  endtask

  task automatic bus_rd(output logic [15:0] d);
    @(negedge clk); cs = 1; rd = 1; #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic set_count(input int v);
    bus_wr(1, 16'h00C2); bus_wr(0, 16'(v));
  endtask

  task automatic clr_int();
    bus_wr(1, 16'h00A4); bus_wr(0, 16'h0004);
  endtask

  task automatic rd_reg(input logic [7:0] c, output logic [15:0] d);
    bus_wr(1, {8'h00, c}); bus_rd(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 rdata", rdata, 16'h0);
    rd_reg(8'h42, d); chk("R1 count", d, 16'h0);
    rd_reg(8'h2C, d); chk("R1 status", d, 16'h0);

    // R2: buffers independent
    set_count(DEPTH);
    bus_wr(1, 16'h00C0);
    for (int i = 0; i < DEPTH / 2; i++) bus_wr(0, {8'hA5 ^ 8'(2*i+1), 8'hA5 ^ 8'(2*i)});
    bus_wr(1, 16'h00C1);
    for (int i = 0; i < DEPTH / 2; i++) bus_wr(0, {8'h3C ^ 8'(2*i+1), 8'h3C ^ 8'(2*i)});
    bus_wr(1, 16'h0040);
    for (int i = 0; i < DEPTH / 2; i++) begin
      bus_rd(d); chk("R2 iso content", d, {8'hA5 ^ 8'(2*i+1), 8'hA5 ^ 8'(2*i)});
    end
    bus_wr(1, 16'h0041);
    for (int i = 0; i < DEPTH / 2; i++) begin
      bus_rd(d); chk("R2 async content", d, {8'h3C ^ 8'(2*i+1), 8'h3C ^ 8'(2*i)});
    end
    exp_stat = 2'b11;

    // R8: write 0 keeps flag, bit 2 clears it
    chk("R5 irq after full", 16'(irq), 16'h1);
    bus_wr(1, 16'h00A4); bus_wr(0, 16'h0000);
    chk("R8 zero write keeps", 16'(irq), 16'h1);
    rd_reg(8'h24, d); chk("R8 int read", d, 16'h0004);
    clr_int();
    chk("R8 clear", 16'(irq), 16'h0);
    rd_reg(8'h24, d); chk("R8 int read cleared", d, 16'h0000);

    // R11: wrong-direction read in a write stream
    set_count(4);
    bus_wr(1, 16'h00C0); exp_stat[0] = 0;
    bus_wr(0, 16'h1122);
    bus_rd(d); chk("R11 read in write stream", d, 16'h0);
    bus_wr(0, 16'h3344);
    chk("R11 eot after two writes", 16'(irq), 16'h1);
    exp_stat[0] = 1;
    bus_wr(1, 16'h0040);
    bus_rd(d); chk("R11 word0", d, 16'h1122);
    bus_rd(d); chk("R11 word1", d, 16'h3344);
    bus_rd(d); chk("R6 read after eot", d, 16'h0);
    clr_int();

    // Sweep over all counts and both buffers
    for (int c = 0; c <= DEPTH + 2; c++) begin
      for (int b = 0; b < 2; b++) begin
        int ec, n;
        ec = (c > DEPTH) ? DEPTH : c;
        n = (ec + 1) / 2;
        set_count(DEPTH);
        bus_wr(1, 16'(8'hC0 | b));
        for (int i = 0; i < DEPTH / 2; i++) bus_wr(0, {bg(b, 2*i+1), bg(b, 2*i)});
        exp_stat[b] = 1;
        clr_int();

        set_count(c);
        rd_reg(8'h42, d); chk("R9 count readback", d, 16'(ec));
        bus_wr(1, 16'(8'hC0 | b)); exp_stat[b] = 0;
        for (int k = 0; k <= n; k++) begin
          if (k == n - 1) chk("R5 irq low before last", 16'(irq), 16'h0);
          bus_wr(0, {fg(b, c, 2*k+1), fg(b, c, 2*k)});
        end
        chk("R5 irq after stream", 16'(irq), 16'(ec != 0));
        if (ec != 0) exp_stat[b] = 1;
        rd_reg(8'h2C, d); chk("R10 status", d, 16'(exp_stat));

        bus_wr(1, 16'(8'h40 | b)); exp_stat[b] = 0;
        for (int k = 0; k < n; k++) begin
          logic [7:0] hi;
          hi = (2*k + 1 < ec) ? fg(b, c, 2*k+1) : 8'h00;
          bus_rd(d); chk("R7 partial read lanes", d, {hi, fg(b, c, 2*k)});
        end
        bus_rd(d); chk("R6 read after eot zero", d, 16'h0);
        if (ec != 0) exp_stat[b] = 1;

        set_count(DEPTH);
        bus_wr(1, 16'(8'h40 | b)); exp_stat[b] = 0;
        for (int i = 0; i < DEPTH / 2; i++) begin
          logic [7:0] lo, hi;
          lo = (2*i < ec) ? fg(b, c, 2*i) : bg(b, 2*i);
          hi = (2*i + 1 < ec) ? fg(b, c, 2*i+1) : bg(b, 2*i+1);
          bus_rd(d); chk("R3 R6 R7 full readback", d, {hi, lo});
        end
        exp_stat[b] = 1;
        clr_int();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule